// File: doc/BRIEF.md
# Dual-Link Half-Word Transmit Duplicator

This block takes 32-bit words from a slow parallel producer, stores them once in a single FIFO, and streams them out as 16-bit half-words. Every half-word leaves on two transmit link ports in the same cycle: a primary acquisition link and a secondary monitoring link. The copy is made after the FIFO read, so both links always see the same data in the same order.

The write side is modelled with one clock and a write clock enable (`in_ce`), which stands for a producer running at half the read rate. A word is written on a clock edge where `in_ce` and `in_valid` are both high. The input has no ready signal. Back-pressure reaches the producer through `link_full`, which rises when the FIFO is half occupied, and the producer is expected to stop writing while it is high. A write that still arrives while the FIFO is completely full is dropped and counted in `ovf_count`.

On the output side, `xoff` acts as the inverse of a ready signal shared by both links. While `xoff` is high, no half-word is issued and the half-select state holds its value. The two `*_valid` strobes are always raised together. They carry no ready of their own, because the links consume a half-word in every cycle in which it is valid.

Top module: `link_dup_tx`

## Requirements
- R1: During and right after reset, `pri_valid`, `sec_valid` and `link_full` are low, `ovf_count` is zero and the FIFO is empty.
- R2: A word is written on a clock edge only when `in_ce` and `in_valid` are both high. When `in_ce` is low, `in_valid` and `in_data` have no effect.
- R3: Each 32-bit word is issued as two half-words: bits [15:0] first, then bits [31:16]. The word leaves the FIFO only after its upper half has been issued.
- R4: `pri_valid` equals `sec_valid` in every cycle. When they are high, `pri_data` equals `sec_data`.
- R5: `link_full` is high exactly when FIFO occupancy is at least DEPTH/2 (32 with the defaults). It rises in the cycle after the write that brings the occupancy to that level.
- R6: If `xoff` is high at a clock edge, no half-word is issued at that edge, so both valid strobes are low in the following cycle. Any pending upper half is held and sent once `xoff` falls.
- R7: A write attempted while the FIFO holds DEPTH words is dropped, and `ovf_count` increases by one, saturating at its maximum.
- R8: Half-words appear on the links in the order in which their words were accepted, with nothing lost or repeated.
- R9: When the FIFO holds a word and `xoff` is low at a clock edge, a half-word is registered at that edge. A word written into an empty FIFO at edge k therefore shows its lower half after edge k+1 and its upper half after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| in_ce | input | 1 | Write-side clock enable |
| in_valid | input | 1 | Input word present (qualified by in_ce) |
| in_data | input | 32 | Input word |
| link_full | output | 1 | FIFO at least half full; producer should pause |
| ovf_count | output | 8 | Saturating count of writes dropped while full |
| xoff | input | 1 | Combined stop request from the links |
| pri_valid | output | 1 | Primary link half-word strobe |
| pri_data | output | 16 | Primary link half-word |
| sec_valid | output | 1 | Secondary link half-word strobe |
| sec_data | output | 16 | Secondary link half-word |

## Verification
A write at edge k updates `link_full` and `ovf_count` just after k. The first half-word it produces is registered at edge k+1 at the earliest. The effect of `xoff` at an edge shows on the valid strobes in the cycle after that edge. The bench drives inputs on falling edges and samples outputs on falling edges. It records the `xoff` value present at each rising edge, so it can tell whether the following output cycle is allowed to carry data. Ordering and half sequencing are checked against a queue of expected half-words, so the exact issue cycle does not matter there. The one place where exact timing is checked is a directed single-word case, which confirms the k+1 and k+2 arrival of the two halves.

// File: rtl/ldt_pkg.sv
package ldt_pkg;
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;
endpackage

// File: rtl/ldt_fifo.sv
module ldt_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 64,
  parameter int OVF_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_req,
  input  logic [W-1:0]               wr_data,
  input  logic                       rd_pop,
  output logic [W-1:0]               head,
  output logic                       empty,
  output logic                       half_full,
  output logic [$clog2(DEPTH):0]     occ,
  output logic [OVF_W-1:0]           ovf_cnt
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = AW + 1;
  localparam int HALFD = DEPTH / 2;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, wr_ok, rd_ok;

  assign full      = (occ == CW'(DEPTH));
  assign empty     = (occ == '0);
  assign half_full = (occ >= CW'(HALFD));
  assign wr_ok     = wr_req && !full;
  assign rd_ok     = rd_pop && !empty;
  assign head      = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      occ     <= '0;
      ovf_cnt <= '0;
    end else begin
      if (wr_ok) wr_ptr <= bump(wr_ptr);
      if (rd_ok) rd_ptr <= bump(rd_ptr);
      case ({wr_ok, rd_ok})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
      if (wr_req && full && (ovf_cnt != '1)) ovf_cnt <= ovf_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ldt_split.sv
module ldt_split
  import ldt_pkg::*;
#(
  parameter int IN_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IN_W-1:0]   head,
  input  logic              empty,
  input  logic              xoff,
  output logic              issue,
  output logic [IN_W/2-1:0] half_data,
  output logic              pop
);
  localparam int OUT_W = IN_W / 2;

  half_e sel;

  assign issue     = !empty && !xoff;
  assign half_data = (sel == HALF_HI) ? head[IN_W-1:OUT_W] : head[OUT_W-1:0];
  assign pop       = issue && (sel == HALF_HI);

  always_ff @(posedge clk) begin
    if (!rst_n)     sel <= HALF_LO;
    else if (issue) sel <= (sel == HALF_HI) ? HALF_LO : HALF_HI;
  end
endmodule

// File: rtl/ldt_fanout.sv
module ldt_fanout #(
  parameter int W  = 16,
  parameter int NL = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 issue,
  input  logic [W-1:0]         data,
  output logic [NL-1:0]        lane_valid,
  output logic [NL-1:0][W-1:0] lane_data
);
  for (genvar g = 0; g < NL; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lane_valid[g] <= 1'b0;
        lane_data[g]  <= '0;
      end else begin
        lane_valid[g] <= issue;
        if (issue) lane_data[g] <= data;
      end
    end
  end
endmodule

// File: rtl/link_dup_tx.sv
module link_dup_tx #(
  parameter int IN_W  = 32,
  parameter int DEPTH = 64,
  parameter int OVF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_ce,
  input  logic              in_valid,
  input  logic [IN_W-1:0]   in_data,
  output logic              link_full,
  output logic [OVF_W-1:0]  ovf_count,
  input  logic              xoff,
  output logic              pri_valid,
  output logic [IN_W/2-1:0] pri_data,
  output logic              sec_valid,
  output logic [IN_W/2-1:0] sec_data
);
  localparam int OUT_W = IN_W / 2;
  localparam int CW    = $clog2(DEPTH) + 1;
  localparam int NL    = 2;

  logic [IN_W-1:0]           head;
  logic                      empty, issue, pop;
  logic [OUT_W-1:0]          half_data;
  logic [CW-1:0]             fifo_occ;
  logic [NL-1:0]             lane_valid;
  logic [NL-1:0][OUT_W-1:0]  lane_data;

  ldt_fifo #(.W(IN_W), .DEPTH(DEPTH), .OVF_W(OVF_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_req    (in_ce && in_valid),
    .wr_data   (in_data),
    .rd_pop    (pop),
    .head      (head),
    .empty     (empty),
    .half_full (link_full),
    .occ       (fifo_occ),
    .ovf_cnt   (ovf_count)
  );

  ldt_split #(.IN_W(IN_W)) u_split (
    .clk       (clk),
    .rst_n     (rst_n),
    .head      (head),
    .empty     (empty),
    .xoff      (xoff),
    .issue     (issue),
    .half_data (half_data),
    .pop       (pop)
  );

  ldt_fanout #(.W(OUT_W), .NL(NL)) u_fan (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (issue),
    .data       (half_data),
    .lane_valid (lane_valid),
    .lane_data  (lane_data)
  );

  assign pri_valid = lane_valid[0];
  assign pri_data  = lane_data[0];
  assign sec_valid = lane_valid[1];
  assign sec_data  = lane_data[1];
endmodule

// File: rtl/ldt_chk.sv
module ldt_chk #(
  parameter int IN_W  = 32,
  parameter int DEPTH = 64,
  parameter int OVF_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_ce,
  input logic                    in_valid,
  input logic                    xoff,
  input logic                    link_full,
  input logic [OVF_W-1:0]        ovf_count,
  input logic                    pri_valid,
  input logic [IN_W/2-1:0]       pri_data,
  input logic                    sec_valid,
  input logic [IN_W/2-1:0]       sec_data,
  input logic [$clog2(DEPTH):0]  occ
);
  localparam int CW = $clog2(DEPTH) + 1;

  a_r4_links_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_valid == sec_valid) && (!pri_valid || (pri_data == sec_data)));

  a_r6_xoff_stall: assert property (@(posedge clk) disable iff (!rst_n)
    xoff |=> (!pri_valid && !sec_valid));

  a_r9_no_issue_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |=> !pri_valid);

  a_r7_ovf_step: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ce && in_valid && (occ == CW'(DEPTH)) && (ovf_count != '1))
      |=> (ovf_count == $past(ovf_count) + 1'b1));

  a_r7_occ_cap: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

  a_r5_full_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_full) |-> (occ == CW'(DEPTH / 2)));
endmodule

bind link_dup_tx ldt_chk #(.IN_W(IN_W), .DEPTH(DEPTH), .OVF_W(OVF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ce     (in_ce),
  .in_valid  (in_valid),
  .xoff      (xoff),
  .link_full (link_full),
  .ovf_count (ovf_count),
  .pri_valid (pri_valid),
  .pri_data  (pri_data),
  .sec_valid (sec_valid),
  .sec_data  (sec_data),
  .occ       (fifo_occ)
);

// File: tb/sim_link_dup_tx.sv
`timescale 1ns/1ps
module sim_link_dup_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_ce = 1'b0, in_valid = 1'b0, xoff = 1'b0;
  logic [31:0] in_data = '0;
  logic        link_full, pri_valid, sec_valid;
  logic [7:0]  ovf_count;
  logic [15:0] pri_data, sec_data;

  int errors = 0, checks = 0, valid_seen = 0;
  bit mon_on = 1'b0, xoff_at_edge = 1'b0, finished = 1'b0;
  logic [15:0] exp_q[$];

  always #2.5 clk = ~clk;

  link_dup_tx u0 (
    .clk(clk), .rst_n(rst_n), .in_ce(in_ce), .in_valid(in_valid),
    .in_data(in_data), .link_full(link_full), .ovf_count(ovf_count),
    .xoff(xoff), .pri_valid(pri_valid), .pri_data(pri_data),
    .sec_valid(sec_valid), .sec_data(sec_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: one write cycle; expected halves go to the scoreboard if accepted
  task automatic put(input logic [31:0] d, input bit acc);
    @(negedge clk);
    in_ce = 1'b1; in_valid = 1'b1; in_data = d;
    if (acc) begin
      exp_q.push_back(d[15:0]);
      exp_q.push_back(d[31:16]);
    end
    @(negedge clk);
    in_ce = 1'b0; in_valid = 1'b0;
  endtask

  // a cycle with in_valid high but in_ce low (R2: must be ignored)
  task automatic noise(input logic [31:0] d);
    in_ce = 1'b0; in_valid = 1'b1; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 600 && exp_q.size() > 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  always @(posedge clk) xoff_at_edge = xoff;

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      if (xoff_at_edge)
        chk(!pri_valid && !sec_valid, "R6 valid after xoff edge", {pri_valid, sec_valid}, 0);
      chk(pri_valid == sec_valid, "R4 strobes together", {pri_valid, sec_valid}, {pri_valid, pri_valid});
      if (pri_valid) begin
        valid_seen++;
        chk(pri_data == sec_data, "R4 link data equal", sec_data, pri_data);
        if (exp_q.size() == 0)
          chk(1'b0, "R8 unexpected half-word", pri_data, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(pri_data == e, "R3 R8 half-word order", pri_data, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!pri_valid && !sec_valid && !link_full && ovf_count == 0, "R1 in reset",
        {pri_valid, sec_valid, link_full, ovf_count}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pri_valid && !sec_valid && !link_full && ovf_count == 0, "R1 after reset",
        {pri_valid, sec_valid, link_full, ovf_count}, 0);
    mon_on = 1'b1;

    // R2: in_valid without in_ce does nothing
    for (int i = 0; i < 6; i++) noise(32'hDEAD0000 + i);
    repeat (3) @(negedge clk);
    chk(valid_seen == 0, "R2 ignored writes", valid_seen, 0);

    // R9: exact latency of a single word
    @(negedge clk);
    in_ce = 1'b1; in_valid = 1'b1; in_data = 32'hBEEF_CAFE;
    exp_q.push_back(16'hCAFE); exp_q.push_back(16'hBEEF);
    @(negedge clk);  // edge k passed
    in_ce = 1'b0; in_valid = 1'b0;
    chk(!pri_valid, "R9 no output after edge k", pri_valid, 0);
    @(negedge clk);
    chk(pri_valid && pri_data == 16'hCAFE, "R9 R3 low half at k+1", {pri_valid, pri_data}, {1'b1, 16'hCAFE});
    @(negedge clk);
    chk(pri_valid && pri_data == 16'hBEEF, "R9 R3 high half at k+2", {pri_valid, pri_data}, {1'b1, 16'hBEEF});
    @(negedge clk);
    chk(!pri_valid, "R3 word popped after high half", pri_valid, 0);

    // slow writer with ignored cycles between words
    for (int i = 0; i < 8; i++) begin
      put(32'h1000_0001 * (i + 1) ^ 32'h5A5A_0F0F, 1'b1);
      noise(32'hFFFF_FFFF);
    end
    drain();
    chk(exp_q.size() == 0, "R8 slow stream drained", exp_q.size(), 0);

    // fill under xoff: link_full threshold and overflow
    xoff = 1'b1;
    for (int i = 0; i < 31; i++) put(32'hA000_0000 + i, 1'b1);
    chk(!link_full, "R5 flag low at 31 words", link_full, 0);
    put(32'hA000_001F, 1'b1);
    chk(link_full, "R5 flag high at 32 words", link_full, 1);
    for (int i = 32; i < 64; i++) put(32'hA000_0000 + i, 1'b1);
    chk(ovf_count == 0, "R7 no overflow when exactly full", ovf_count, 0);
    for (int i = 0; i < 3; i++) put(32'hBAD0_0000 + i, 1'b0);
    chk(ovf_count == 3, "R7 dropped writes counted", ovf_count, 3);
    chk(valid_seen == 18, "R6 nothing issued under xoff", valid_seen, 18);
    xoff = 1'b0;
    drain();
    chk(exp_q.size() == 0, "R8 full buffer drained", exp_q.size(), 0);
    chk(!link_full, "R5 flag low after drain", link_full, 0);

    // xoff toggling while streaming (half-select must hold across stalls)
    fork
      for (int i = 0; i < 12; i++) put(32'h7000_0000 | (i << 20) | (i * 3), 1'b1);
      for (int i = 0; i < 70; i++) begin
        @(negedge clk);
        xoff = ((i % 5) < 2);
      end
    join
    xoff = 1'b0;
    drain();
    chk(exp_q.size() == 0, "R6 R8 stream with stalls drained", exp_q.size(), 0);
    chk(valid_seen == 18 + 128 + 24, "R8 total half-words", valid_seen, 18 + 128 + 24);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule